// File: doc/BRIEF.md
# SMBus Register Target with Packet Error Code and Clock-Low Timeout

This block is the target end of a two-wire system-management link. A fast system clock oversamples the bus clock and data lines. Each line passes through a two-flop synchroniser and a glitch filter. The block then finds bus edges, START and STOP conditions. It drives the data line only through an open-drain pull-down enable. A master addresses it with a 7-bit address and then names one of a small set of internal 8-bit registers with a one-byte command code. Three message types are handled:

- a byte write into the named register;
- a command-only message that clears the named register;
- a byte read that follows a repeated START.

An optional CRC-8 packet error code guards every message. It covers every byte, the address bytes included. When it is enabled, the block checks the code on writes and appends it on reads.

A held-low bus clock that lasts longer than a parameterised count abandons the transfer. Unknown command codes are refused. Three sticky error flags report failures, and a single clear input resets them. The bus carries data bit-serially and the block never stretches the clock, so the block has no streaming data edge and no back-pressure. The register file is observed through a plain combinational read port (`rd_sel` in, `rd_data` out), which is valid on every cycle.

Top module: `smb_target`

## Requirements
- R1: Out of reset, `sda_oe` is 0, all registers read 0 and `err_pec`, `err_cmd` and `err_to` are 0.
- R2: The first byte after a START is acknowledged only when its upper seven bits equal `OWN_ADDR`. Bit 0 of that byte is the direction: 1 means read, 0 means write. Any other address gets no acknowledge, and the rest of that message changes nothing.
- R3: A write message has the form address(write), command, data, STOP, with bytes sent most significant bit first. When the command is below `NUM_REGS`, it loads the data into register[command], and every byte is acknowledged.
- R4: A message with only address(write), command and STOP (no data byte) clears register[command] to 0x00.
- R5: A command code of `NUM_REGS` or above is not acknowledged. It sets `err_cmd`, which stays set, and it changes no register.
- R6: A read message has the form address(write), command, repeated START, address(read). The block then sends register[command] most significant bit first. Once the master does not acknowledge that byte, the block stops driving the line.
- R7: With `pec_en` high, a trailing code byte follows the last byte. The code is CRC-8 with polynomial 0x07 and initial value 0x00, taken over every byte from the first address byte on. A correct code is acknowledged and the write commits.
- R8: With `pec_en` high, a wrong code byte after a data byte is not acknowledged. On a wrong code, with or without a data byte, no register changes and `err_pec` is set and stays set.
- R9: With `pec_en` high, if the master acknowledges the read data byte, the block next sends the CRC-8 of the address(write), command, address(read) and data bytes.
- R10: If the bus clock stays low for more than `TIMEOUT_CYC` system cycles during a message, the block stops driving the line and drops the message, so a later STOP commits nothing. It also sets `err_to`.
- R11: A cycle with `err_clr` high clears all three error flags.
- R12: A pulse on either bus line shorter than `FILT_CYC` system cycles is ignored.
- R13: A write takes effect only at the STOP that ends its message. Before that STOP, the register still reads its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low |
| pec_en | input | 1 | Enables packet error code check and generation |
| rd_sel | input | PTR_W | Register index for the local read port |
| rd_data | output | 8 | Contents of register `rd_sel` |
| err_clr | input | 1 | Clears the sticky error flags |
| err_pec | output | 1 | Sticky: a packet error code mismatch was seen |
| err_cmd | output | 1 | Sticky: an unsupported command code was refused |
| err_to | output | 1 | Sticky: a clock-low timeout aborted a message |

## Verification
The bench checks each write at the cycle before its STOP. A design that commits as each byte arrives would change the register early. The bench sends a wrong address, an out-of-range command and a corrupted code byte, both with and without a data byte. A design that leaks these would then alter a register, acknowledge wrongly, or leave an error flag clear. The bench also holds the clock low while the target is driving a read bit, and again midway through a write. A target without the timeout would keep the line pulled low or commit a write at the late STOP. A short glitch on the clock inside a byte would shift in an extra bit if the filter were missing.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK, S_WAIT
  } smb_state_t;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++)
      x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) cnt_q <= '0;
      else if (cnt_q == CW'(FILT_CYC - 1)) begin
        line_o <= sync_q[1];
        cnt_q  <= '0;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_p;
  assign scl_fall  = ~scl & scl_p;
  assign start_det = scl & scl_p & sda_p & ~sda;
  assign stop_det  = scl & scl_p & ~sda_p & sda;
endmodule

// File: rtl/smb_target.sv
module smb_target
  import smb_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h2A,
  parameter int         NUM_REGS    = 4,
  parameter int         FILT_CYC    = 4,
  parameter int         TIMEOUT_CYC = 8750000,
  localparam int        PTR_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             pec_en,
  input  logic [PTR_W-1:0] rd_sel,
  output logic [7:0]       rd_data,
  input  logic             err_clr,
  output logic             err_pec,
  output logic             err_cmd,
  output logic             err_to
);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

  // line conditioning, one filter per wire
  logic [1:0] raw, filt;
  assign raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    smb_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw[g]), .line_o(filt[g]));
  end
  logic scl_f, sda_f;
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  logic scl_rise, scl_fall, start_det, stop_det;
  smb_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  smb_state_t       st;
  logic             busy, rd_act, cmd_ok, pec_sent, go_tx, mack;
  logic [3:0]       bitcnt;
  logic [2:0]       nbyte;
  logic [7:0]       shreg, txsh, crc, stage;
  logic [PTR_W-1:0] ptr;
  logic [TO_W-1:0]  to_cnt;
  logic             to_hit;

  // register file
  logic [7:0] regs [NUM_REGS];
  logic       commit;
  logic [7:0] commit_val;
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (commit && ptr == PTR_W'(g)) q <= commit_val;
    end
    assign regs[g] = q;
  end
  assign rd_data = regs[rd_sel];

  // byte decision at the end of a received byte
  logic [7:0] crc_n;
  logic       dec_ack, dec_read, rx_done;
  assign crc_n = crc8_step(crc, shreg);
  always_comb begin
    dec_ack  = 1'b0;
    dec_read = 1'b0;
    case (nbyte)
      3'd0: begin dec_ack = (shreg[7:1] == OWN_ADDR); dec_read = shreg[0]; end
      3'd1: dec_ack = (int'(shreg) < NUM_REGS);
      3'd2: dec_ack = 1'b1;
      3'd3: dec_ack = pec_en && (crc_n == 8'h00);
      default: dec_ack = 1'b0;
    endcase
  end
  assign rx_done = (st == S_RX) && scl_fall && (bitcnt == 4'd8)
                   && !to_hit && !stop_det && !start_det;

  // end-of-message decision
  logic send_end, write_end, end_ok, crc_good;
  assign send_end   = (nbyte == (pec_en ? 3'd3 : 3'd2));
  assign write_end  = (nbyte == (pec_en ? 3'd4 : 3'd3));
  assign end_ok     = busy && !rd_act && cmd_ok && (send_end || write_end);
  assign crc_good   = !pec_en || (crc == 8'h00);
  assign commit     = stop_det && !to_hit && end_ok && crc_good;
  assign commit_val = write_end ? stage : 8'h00;

  // clock-low timeout
  assign to_hit = busy && !scl_f && (to_cnt == TO_W'(TIMEOUT_CYC));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) to_cnt <= '0;
    else if (!busy || scl_f) to_cnt <= '0;
    else if (to_cnt != TO_W'(TIMEOUT_CYC)) to_cnt <= to_cnt + 1'b1;
  end

  // sticky error flags, a new event wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pec <= 1'b0;
      err_cmd <= 1'b0;
      err_to  <= 1'b0;
    end else begin
      err_pec <= (err_pec & ~err_clr) | (stop_det && !to_hit && end_ok && !crc_good);
      err_cmd <= (err_cmd & ~err_clr) | (rx_done && nbyte == 3'd1 && !dec_ack);
      err_to  <= (err_to & ~err_clr) | to_hit;
    end
  end

  // transfer engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; busy <= 1'b0; sda_oe <= 1'b0; rd_act <= 1'b0;
      cmd_ok <= 1'b0; pec_sent <= 1'b0; go_tx <= 1'b0; mack <= 1'b0;
      bitcnt <= '0; nbyte <= '0; shreg <= '0; txsh <= '0; crc <= '0;
      stage <= '0; ptr <= '0;
    end else if (to_hit || stop_det) begin
      st <= S_IDLE; busy <= 1'b0; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= S_RX; busy <= 1'b1; sda_oe <= 1'b0; bitcnt <= '0;
      nbyte <= '0; pec_sent <= 1'b0; rd_act <= 1'b0;
      if (!busy) begin crc <= '0; cmd_ok <= 1'b0; end
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (rx_done) begin
            crc    <= crc_n;
            nbyte  <= (nbyte == 3'd7) ? nbyte : nbyte + 3'd1;
            sda_oe <= dec_ack;
            go_tx  <= dec_ack && nbyte == 3'd0 && dec_read;
            if (nbyte == 3'd1 && dec_ack) begin
              ptr    <= shreg[PTR_W-1:0];
              cmd_ok <= 1'b1;
            end
            if (nbyte == 3'd2) stage <= shreg;
            st <= dec_ack ? S_RXACK : S_WAIT;
          end
        end
        S_RXACK: if (scl_fall) begin
          bitcnt <= '0;
          if (go_tx) begin
            txsh   <= regs[ptr];
            crc    <= crc8_step(crc, regs[ptr]);
            sda_oe <= ~regs[ptr][7];
            rd_act <= 1'b1;
            st     <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0;
            st     <= S_TXACK;
          end else begin
            txsh   <= txsh << 1;
            sda_oe <= ~txsh[6];
            bitcnt <= bitcnt + 4'd1;
          end
        end
        S_TXACK: begin
          if (scl_rise) mack <= !sda_f;
          else if (scl_fall) begin
            if (mack && pec_en && !pec_sent) begin
              txsh     <= crc;
              sda_oe   <= ~crc[7];
              pec_sent <= 1'b1;
              bitcnt   <= '0;
              st       <= S_TX;
            end else st <= S_WAIT;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_oe,
  input logic busy,
  input logic to_hit,
  input logic err_pec,
  input logic err_cmd,
  input logic err_clr
);
  AST_OE_NEEDS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy); // R2

  AST_DRIVE_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f); // R6

  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> (!sda_oe && !busy)); // R10

  AST_PEC_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pec && !err_clr) |=> err_pec); // R8

  AST_CMD_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cmd && !err_clr) |=> err_cmd); // R5
endmodule

bind smb_target smb_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe), .busy(busy),
  .to_hit(to_hit), .err_pec(err_pec), .err_cmd(err_cmd), .err_clr(err_clr));

// File: tb/smb_target_test.sv
module smb_target_test;
  localparam int H    = 40;
  localparam int TO   = 3000;
  localparam logic [6:0] ADR = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, pec_en = 1'b0, err_clr = 1'b0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic sda_oe, err_pec, err_cmd, err_to, sda_line;
  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 1'b0;
  logic [7:0] mregs [4];
  bit mpec = 0, mcmd = 0, mto = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smb_target #(.OWN_ADDR(ADR), .NUM_REGS(4), .FILT_CYC(4), .TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pec_en(pec_en), .rd_sel(rd_sel), .rd_data(rd_data), .err_clr(err_clr),
    .err_pec(err_pec), .err_cmd(err_cmd), .err_to(err_to));

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model compared on every idle clock
  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      checks++;
      if (rd_data !== mregs[rd_sel] || err_pec !== mpec || err_cmd !== mcmd || err_to !== mto) begin
        errors++;
        $display("FAIL R13 model actual=%0h/%0b%0b%0b expected=%0h/%0b%0b%0b",
                 rd_data, err_pec, err_cmd, err_to, mregs[rd_sel], mpec, mcmd, mto);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1; scl_m = 1; wait_n(H); sda_m = 0; wait_n(H); scl_m = 0;
  endtask
  task automatic brs();
    wait_n(H/2); sda_m = 1; wait_n(H/2); scl_m = 1; wait_n(H); sda_m = 0; wait_n(H); scl_m = 0;
  endtask
  task automatic bstop();
    wait_n(H/2); sda_m = 0; wait_n(H/2); scl_m = 1; wait_n(H); sda_m = 1; wait_n(H);
  endtask

  task automatic wbyte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      wait_n(H/2); sda_m = b[i];
      if (glitch && i == 4) begin wait_n(4); scl_m = 1; wait_n(2); scl_m = 0; end
      wait_n(H/2); scl_m = 1; wait_n(H); scl_m = 0;
    end
    wait_n(H/2); sda_m = 1; wait_n(H/2); scl_m = 1;
    wait_n(H/2); ack = !sda_line; wait_n(H/2); scl_m = 0;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(H); scl_m = 1; wait_n(H/2); b[i] = sda_line; wait_n(H/2); scl_m = 0;
    end
    wait_n(H/2); sda_m = !mack; wait_n(H/2); scl_m = 1; wait_n(H); scl_m = 0;
  endtask

  // write-type message without STOP; pm: 0 none, 1 good code, 2 bad code
  task automatic wr_msg(input logic [6:0] a, input logic [7:0] cmd, input bit has_d,
                        input logic [7:0] d, input int pm, input bit glitch, output bit [3:0] acks);
    logic [7:0] c;
    cmp_on = 0; acks = '0; c = 8'h00;
    bstart();
    wbyte({a, 1'b0}, 0, acks[0]); c = crc8(c, {a, 1'b0});
    wbyte(cmd, 0, acks[1]);       c = crc8(c, cmd);
    if (has_d) begin wbyte(d, glitch, acks[2]); c = crc8(c, d); end
    if (pm != 0) wbyte((pm == 1) ? c : (c ^ 8'h01), 0, acks[3]);
  endtask

  task automatic settle();
    bstop(); wait_n(20); cmp_on = 1; wait_n(5);
  endtask

  task automatic peek(input int sel, input int exp, input string tag);
    @(negedge clk); rd_sel = 2'(sel); #1; check(tag, rd_data, exp);
  endtask

  task automatic clear_errs();
    cmp_on = 0; @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    mpec = 0; mcmd = 0; mto = 0; wait_n(2); cmp_on = 1;
    check("R11 err_pec cleared", err_pec, 0);
    check("R11 err_cmd cleared", err_cmd, 0);
    check("R11 err_to cleared", err_to, 0);
  endtask

  task automatic rd_msg(input logic [7:0] cmd, input bit pec, input logic [7:0] exp, input string tag);
    bit a0, a1, a2;
    logic [7:0] d, p, c;
    cmp_on = 0;
    bstart();
    wbyte({ADR, 1'b0}, 0, a0); wbyte(cmd, 0, a1); brs(); wbyte({ADR, 1'b1}, 0, a2);
    check({tag, " acks"}, {a0, a1, a2}, 3'b111);
    rbyte(pec, d);
    check({tag, " data"}, d, exp);
    if (pec) begin
      c = crc8(crc8(crc8(crc8(8'h00, {ADR, 1'b0}), cmd), {ADR, 1'b1}), d);
      rbyte(0, p);
      check("R9 read code byte", p, c);
    end
    wait_n(20);
    check("R6 released after master NACK", sda_oe, 0);
    settle();
  endtask

  initial begin
    bit [3:0] ak;
    for (int i = 0; i < 4; i++) mregs[i] = 8'h00;
    wait_n(5); rst_n = 1; wait_n(5);
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 flags after reset", {err_pec, err_cmd, err_to}, 0);
    peek(2, 8'h00, "R1 reg after reset");
    cmp_on = 1;

    // R3 + R13
    rd_sel = 2'd1;
    wr_msg(ADR, 8'h01, 1, 8'hA5, 0, 0, ak);
    check("R3 write acks", ak[2:0], 3'b111);
    wait_n(10); check("R13 value before STOP", rd_data, 8'h00);
    bstop(); mregs[1] = 8'hA5; wait_n(20); cmp_on = 1;
    peek(1, 8'hA5, "R3 written value");

    // R2 wrong address
    wr_msg(7'h2B, 8'h02, 1, 8'hFF, 0, 0, ak);
    check("R2 foreign address not acked", ak[2:0], 3'b000);
    settle(); peek(2, 8'h00, "R2 foreign write ignored");

    wr_msg(ADR, 8'h02, 1, 8'h3C, 0, 0, ak); mregs[2] = 8'h3C; settle();
    wr_msg(ADR, 8'h03, 1, 8'h81, 0, 0, ak); mregs[3] = 8'h81; settle();
    peek(3, 8'h81, "R3 second pattern");

    // R6 reads
    rd_msg(8'h01, 0, 8'hA5, "R6 read reg1");
    rd_msg(8'h03, 0, 8'h81, "R6 read reg3");

    // R4 command-only clears
    wr_msg(ADR, 8'h03, 0, 8'h00, 0, 0, ak);
    check("R4 acks", ak[1:0], 2'b11);
    mregs[3] = 8'h00; settle(); peek(3, 8'h00, "R4 register cleared");

    // R5 unsupported command
    wr_msg(ADR, 8'h05, 1, 8'h77, 0, 0, ak);
    check("R5 command NACK", ak[1], 0);
    mcmd = 1; settle();
    check("R5 err_cmd set", err_cmd, 1);
    clear_errs();

    // R7 good code on write
    pec_en = 1;
    wr_msg(ADR, 8'h00, 1, 8'h77, 1, 0, ak);
    check("R7 code byte acked", ak, 4'b1111);
    mregs[0] = 8'h77; settle(); peek(0, 8'h77, "R7 committed");

    // R8 bad code on write and on command-only
    wr_msg(ADR, 8'h00, 1, 8'h11, 2, 0, ak);
    check("R8 bad code NACK", ak[3], 0);
    mpec = 1; settle(); peek(0, 8'h77, "R8 write discarded");
    check("R8 err_pec set", err_pec, 1);
    clear_errs();
    wr_msg(ADR, 8'h01, 0, 8'h00, 2, 0, ak);
    mpec = 1; settle(); peek(1, 8'hA5, "R8 clear discarded");
    clear_errs();
    wr_msg(ADR, 8'h02, 0, 8'h00, 1, 0, ak);
    mregs[2] = 8'h00; settle(); peek(2, 8'h00, "R7 command-only with code");

    // R9 read with code
    rd_msg(8'h00, 1, 8'h77, "R9 read reg0");
    pec_en = 0; wait_n(5);

    // R12 glitch inside a byte
    wr_msg(ADR, 8'h01, 1, 8'h5A, 0, 1, ak);
    check("R12 acks with glitch", ak[2:0], 3'b111);
    mregs[1] = 8'h5A; settle(); peek(1, 8'h5A, "R12 glitch ignored");

    // R10 timeout while target drives a read bit
    cmp_on = 0;
    bstart();
    wbyte({ADR, 1'b0}, 0, ak[0]); wbyte(8'h01, 0, ak[1]); brs(); wbyte({ADR, 1'b1}, 0, ak[2]);
    wait_n(30);
    check("R10 driving before timeout", sda_oe, 1);
    wait_n(TO + 200);
    check("R10 released after timeout", sda_oe, 0);
    check("R10 err_to set", err_to, 1);
    mto = 1; settle();
    clear_errs();

    // R10 timeout mid-write, late STOP commits nothing
    wr_msg(ADR, 8'h02, 1, 8'h99, 0, 0, ak);
    wait_n(TO + 200);
    mto = 1; settle(); peek(2, 8'h00, "R10 aborted write dropped");
    clear_errs();
    wr_msg(ADR, 8'h02, 1, 8'h42, 0, 0, ak); mregs[2] = 8'h42; settle();
    peek(2, 8'h42, "R10 recovery write");

    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule